// File: doc/BRIEF.md
# Round-Robin Event Distributor

The block takes the words of one collision event as they arrive at clock rate. It holds them and then plays the whole event out to a single processing-node port, one word per bunch-crossing tick, so an event of `N_BX` words spans `N_BX` crossings. Each new event is sent to the next node port in a fixed rotation over `NODES` ports, and `NODES` must be at least `N_BX`. The schedule is fixed and depends only on the order of arrival, so the block needs no arbitration.

An event starts with a word flagged as start-of-event. The position of a word within its event is its slot number, and slot number means tower position: slot 0 is the lowest |η| and each later slot lies further out. Inside a word, each φ lane keeps its own bit field, and the block never moves those bits. Each node port has two event buffers. A port can therefore take in a new event while it is still sending the previous one.

If an event is directed at a port whose two buffers are both still occupied, the block drops that event and raises a sticky overflow flag.

Top module: `tmx_distributor`

## Requirements
- R1: During reset and in the first cycle after reset, every `out_valid` and `out_sof` bit is 0 and `overflow` is 0.
- R2: The k-th start-of-event since reset (counting from 0) goes to node port k mod `NODES`. This holds even when that event is dropped.
- R3: A port that holds a complete event sends one word per `bx_tick`, in slot order 0 to `N_BX-1`. Each word is presented with `out_valid` high during the single clock cycle that follows the tick.
- R4: `out_sof` is high together with the slot-0 word of each event and is low for every other word.
- R5: The word sent for slot i is bit-identical to the input word of slot i. No φ lane changes its bit position.
- R6: A port sends nothing on a tick while it holds no complete event. An event becomes eligible on the first tick after the clock edge that captures its last word.
- R7: A second event can be captured into a port while that port is sending an earlier one. It is then sent on the ticks straight after the earlier one, with no idle tick in between.
- R8: A start-of-event aimed at a port with both buffers occupied sets `overflow`, which stays at 1 until reset. That event is never sent, and the buffered events are sent intact.
- R9: Valid words that arrive with no event open, and words after the `N_BX`-th word of an event, are ignored.
- R10: A start-of-event that arrives before the open event is complete abandons the open event, and that partial event is never sent.
- R11: All ports advance on the same tick, so several ports can send words in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_tick | input | 1 | One-cycle pulse per bunch crossing; each port sends one word per pulse |
| in_valid | input | 1 | Input word is present |
| in_sof | input | 1 | Input word is slot 0 of a new event |
| in_data | input | W | Input word; its slot is given by its arrival order |
| out_valid | output | NODES | Per-port word-present flag |
| out_sof | output | NODES | Per-port start-of-event flag |
| out_data | output | NODES*W | Per-port words; port k uses bits [k*W +: W] |
| overflow | output | 1 | Sticky flag: an event was dropped because its port was busy |

## Verification
The assertions check three rules on every cycle. First, `overflow` never falls back to 0 once set, and it rises only after an input start-of-event. Second, no port raises `out_sof` without `out_valid`. Third, no port presents a word except in the cycle that follows a tick.

Only the bench scenarios can show the content-level behaviour: the round-robin port choice, bit-exact slot ordering, back-to-back draining of the second buffer, and that dropped, partial and stray words never appear at any port.

// File: rtl/tmx_pkg.sv
package tmx_pkg;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_FILL = 1'b1
    } cap_state_e;

    // Wrap-around increment for a rotating index bounded by limit-1.
    function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned limit);
        return (cur + 1 >= limit) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/tmx_capture.sv
module tmx_capture #(
    parameter int NODES = 5,
    parameter int N_BX  = 4,
    parameter int W     = 32,
    localparam int PW   = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int SW   = (N_BX > 1) ? $clog2(N_BX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [W-1:0]     in_data,
    input  logic [NODES-1:0] bank_held,
    output logic [NODES-1:0] wr_en,
    output logic [SW-1:0]    wr_slot,
    output logic [W-1:0]     wr_data,
    output logic             wr_last,
    output logic             overflow
);
    import tmx_pkg::*;

    localparam logic [SW-1:0] SLOT_LAST = SW'(N_BX - 1);

    typedef struct packed {
        cap_state_e    state;
        logic [PW-1:0] ptr;
        logic [PW-1:0] node;
        logic [SW-1:0] idx;
        logic          ovf;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d   = cap_q;
        wr_en   = '0;
        wr_slot = '0;
        wr_last = 1'b0;
        wr_data = in_data;
        if (in_valid && in_sof) begin
            // Rotation advances on every event, kept or dropped.
            cap_d.ptr  = PW'(wrap_next(int'(cap_q.ptr), NODES));
            cap_d.node = cap_q.ptr;
            cap_d.idx  = '0;
            if (bank_held[cap_q.ptr]) begin
                cap_d.ovf   = 1'b1;
                cap_d.state = CAP_IDLE;
            end else begin
                wr_en[cap_q.ptr] = 1'b1;
                if (N_BX == 1) begin
                    wr_last     = 1'b1;
                    cap_d.state = CAP_IDLE;
                end else begin
                    cap_d.state = CAP_FILL;
                    cap_d.idx   = SW'(1);
                end
            end
        end else if (in_valid && cap_q.state == CAP_FILL) begin
            wr_en[cap_q.node] = 1'b1;
            wr_slot           = cap_q.idx;
            if (cap_q.idx == SLOT_LAST) begin
                wr_last     = 1'b1;
                cap_d.state = CAP_IDLE;
                cap_d.idx   = '0;
            end else begin
                cap_d.idx = cap_q.idx + SW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '{state: CAP_IDLE, ptr: '0, node: '0, idx: '0, ovf: 1'b0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign overflow = cap_q.ovf;

endmodule

// File: rtl/tmx_node_port.sv
module tmx_node_port #(
    parameter int N_BX = 4,
    parameter int W    = 32,
    localparam int SW  = (N_BX > 1) ? $clog2(N_BX) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bx_tick,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [W-1:0]  wr_data,
    input  logic          wr_last,
    output logic          bank_held,
    output logic          out_valid,
    output logic          out_sof,
    output logic [W-1:0]  out_data
);
    localparam logic [SW-1:0] SLOT_LAST = SW'(N_BX - 1);

    typedef struct packed {
        logic [1:0][N_BX-1:0][W-1:0] mem;
        logic [1:0]                  full;
        logic                        wr_bank;
        logic                        rd_bank;
        logic [SW-1:0]               rd_idx;
        logic                        o_valid;
        logic                        o_sof;
        logic [W-1:0]                o_data;
    } port_t;

    port_t port_d, port_q;

    always_comb begin
        port_d         = port_q;
        port_d.o_valid = 1'b0;
        port_d.o_sof   = 1'b0;
        // Capture side: only reaches a bank that is not full.
        if (wr_en) begin
            port_d.mem[port_q.wr_bank][wr_slot] = wr_data;
            if (wr_last) begin
                port_d.full[port_q.wr_bank] = 1'b1;
                port_d.wr_bank              = ~port_q.wr_bank;
            end
        end
        // Drain side: one word per crossing from a full bank.
        if (bx_tick && port_q.full[port_q.rd_bank]) begin
            port_d.o_valid = 1'b1;
            port_d.o_sof   = (port_q.rd_idx == '0);
            port_d.o_data  = port_q.mem[port_q.rd_bank][port_q.rd_idx];
            if (port_q.rd_idx == SLOT_LAST) begin
                port_d.full[port_q.rd_bank] = 1'b0;
                port_d.rd_bank              = ~port_q.rd_bank;
                port_d.rd_idx               = '0;
            end else begin
                port_d.rd_idx = port_q.rd_idx + SW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign bank_held = port_q.full[port_q.wr_bank];
    assign out_valid = port_q.o_valid;
    assign out_sof   = port_q.o_sof;
    assign out_data  = port_q.o_data;

endmodule

// File: rtl/tmx_distributor.sv
module tmx_distributor #(
    parameter int NODES = 5,
    parameter int N_BX  = 4,
    parameter int W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bx_tick,
    input  logic               in_valid,
    input  logic               in_sof,
    input  logic [W-1:0]       in_data,
    output logic [NODES-1:0]   out_valid,
    output logic [NODES-1:0]   out_sof,
    output logic [NODES*W-1:0] out_data,
    output logic               overflow
);
    localparam int SW = (N_BX > 1) ? $clog2(N_BX) : 1;

    logic [NODES-1:0] wr_en;
    logic [NODES-1:0] bank_held;
    logic [SW-1:0]    wr_slot;
    logic [W-1:0]     wr_data;
    logic             wr_last;

    tmx_capture #(.NODES(NODES), .N_BX(N_BX), .W(W)) capture_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_data   (in_data),
        .bank_held (bank_held),
        .wr_en     (wr_en),
        .wr_slot   (wr_slot),
        .wr_data   (wr_data),
        .wr_last   (wr_last),
        .overflow  (overflow)
    );

    for (genvar k = 0; k < NODES; k++) begin : g_port
        tmx_node_port #(.N_BX(N_BX), .W(W)) port_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .bx_tick   (bx_tick),
            .wr_en     (wr_en[k]),
            .wr_slot   (wr_slot),
            .wr_data   (wr_data),
            .wr_last   (wr_last),
            .bank_held (bank_held[k]),
            .out_valid (out_valid[k]),
            .out_sof   (out_sof[k]),
            .out_data  (out_data[k*W +: W])
        );
    end

endmodule

// File: rtl/tmx_distributor_chk.sv
module tmx_distributor_chk #(
    parameter int NODES = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bx_tick,
    input logic             in_valid,
    input logic             in_sof,
    input logic [NODES-1:0] out_valid,
    input logic [NODES-1:0] out_sof,
    input logic             overflow
);
    // R8: overflow stays high once raised.
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R8: overflow only rises after an incoming start-of-event.
    a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(in_valid && in_sof));

    // R4: start flag never appears without a word.
    a_r4_sof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof & ~out_valid) == '0);

    // R3 / R6: a word is presented only in the cycle after a tick.
    a_r3_word_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid != '0) |-> $past(bx_tick));

endmodule

bind tmx_distributor tmx_distributor_chk #(.NODES(NODES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bx_tick   (bx_tick),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .overflow  (overflow)
);

// File: tb/tmx_distributor_tb_top.sv
module tmx_distributor_tb_top;
    localparam int NODES = 5;
    localparam int N_BX  = 4;
    localparam int W     = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bx_tick = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_sof = 1'b0;
    logic [W-1:0]       in_data = '0;
    logic [NODES-1:0]   out_valid;
    logic [NODES-1:0]   out_sof;
    logic [NODES*W-1:0] out_data;
    logic               overflow;

    int total = 0;
    int bad   = 0;
    int exp_ev [NODES];

    always #2 clk = ~clk;

    tmx_distributor #(.NODES(NODES), .N_BX(N_BX), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bx_tick(bx_tick), .in_valid(in_valid),
        .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid),
        .out_sof(out_sof), .out_data(out_data), .overflow(overflow)
    );

    // Event id in bits 15:8, expected port in bits 7:0.
    localparam logic [15:0] VEC [6] = '{16'h1100, 16'h2201, 16'h3302,
                                         16'h4403, 16'h5504, 16'h6600};

    function automatic logic [W-1:0] ev_word(input int ev, input int slot);
        logic [7:0] e8 = 8'(ev);
        logic [7:0] s8 = 8'(slot);
        return {e8 ^ 8'h5A, s8, ~e8, s8 ^ 8'hC3};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bx_tick = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_word(input bit sof, input logic [W-1:0] data);
        @(negedge clk);
        in_valid = 1'b1; in_sof = sof; in_data = data;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic send_event(input int ev, input int nwords);
        for (int s = 0; s < nwords; s++) send_word(s == 0, ev_word(ev, s));
    endtask

    task automatic clear_exp();
        for (int k = 0; k < NODES; k++) exp_ev[k] = -1;
    endtask

    // Pulse a tick, then compare every port with exp_ev at this slot.
    task automatic tick_check(input int slot, input string req);
        @(negedge clk);
        bx_tick = 1'b1;
        @(negedge clk);
        bx_tick = 1'b0;
        for (int k = 0; k < NODES; k++) begin
            if (exp_ev[k] >= 0) begin
                check(out_valid[k] == 1'b1, req, $sformatf("port %0d valid", k),
                      W'(out_valid[k]), W'(1));
                check(out_sof[k] == (slot == 0), req, $sformatf("port %0d sof", k),
                      W'(out_sof[k]), W'(slot == 0));
                check(out_data[k*W +: W] == ev_word(exp_ev[k], slot), req,
                      $sformatf("port %0d data slot %0d", k, slot),
                      out_data[k*W +: W], ev_word(exp_ev[k], slot));
            end else begin
                check(out_valid[k] == 1'b0, req, $sformatf("port %0d idle", k),
                      W'(out_valid[k]), W'(0));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_exp();
        // R1: state during and just after reset.
        @(negedge clk);
        check(out_valid == '0 && out_sof == '0, "R1", "outputs in reset",
              W'({out_valid, out_sof}), '0);
        do_reset();
        check(out_valid == '0 && out_sof == '0, "R1", "outputs after reset",
              W'({out_valid, out_sof}), '0);
        check(overflow == 1'b0, "R1", "overflow after reset", W'(overflow), '0);
        tick_check(0, "R6 empty tick");

        // Table walk: R2 rotation, R3 one word per tick, R4 sof, R5 bit-exact.
        foreach (VEC[i]) begin
            send_event(int'(VEC[i][15:8]), N_BX);
            clear_exp();
            exp_ev[VEC[i][7:0]] = int'(VEC[i][15:8]);
            for (int s = 0; s < N_BX; s++) tick_check(s, "R2 R3 R4 R5 table");
            clear_exp();
            tick_check(0, "R6 drained");
        end

        // R6: incomplete event is not sent; becomes eligible once complete.
        do_reset();
        send_word(1'b1, ev_word(8'h21, 0));
        send_word(1'b0, ev_word(8'h21, 1));
        clear_exp();
        tick_check(0, "R6 incomplete");
        send_word(1'b0, ev_word(8'h21, 2));
        send_word(1'b0, ev_word(8'h21, 3));
        exp_ev[0] = 8'h21;
        for (int s = 0; s < N_BX; s++) tick_check(s, "R6 complete");

        // R10: partial event abandoned by the next start-of-event.
        do_reset();
        send_word(1'b1, ev_word(8'h31, 0));
        send_word(1'b0, ev_word(8'h31, 1));
        send_event(8'h32, N_BX);
        clear_exp();
        exp_ev[1] = 8'h32;
        for (int s = 0; s < N_BX; s++) tick_check(s, "R10 next event");
        clear_exp();
        tick_check(0, "R10 partial never sent");

        // R9: stray words and surplus words are ignored.
        do_reset();
        send_word(1'b0, 32'hDEAD_0001);
        send_word(1'b0, 32'hDEAD_0002);
        tick_check(0, "R9 stray");
        send_event(8'h41, N_BX + 2);
        exp_ev[0] = 8'h41;
        for (int s = 0; s < N_BX; s++) tick_check(s, "R9 surplus");
        clear_exp();
        tick_check(0, "R9 surplus not sent");

        // R7 / R8 / R11: fill both buffers of every port, then overflow.
        do_reset();
        for (int e = 0; e < 2 * NODES; e++) send_event(8'h50 + e, N_BX);
        check(overflow == 1'b0, "R7", "double buffer accepted", W'(overflow), '0);
        send_event(8'h5A, N_BX);
        check(overflow == 1'b1, "R8", "overflow set", W'(overflow), W'(1));
        for (int k = 0; k < NODES; k++) exp_ev[k] = 8'h50 + k;
        for (int s = 0; s < N_BX; s++) tick_check(s, "R11 parallel drain");
        for (int k = 0; k < NODES; k++) exp_ev[k] = 8'h55 + k;
        for (int s = 0; s < N_BX; s++) tick_check(s, "R7 back to back");
        clear_exp();
        tick_check(0, "R8 dropped event");
        repeat (5) @(negedge clk);
        check(overflow == 1'b1, "R8", "overflow sticky", W'(overflow), W'(1));
        // R2: rotation advanced past the dropped event to port 1.
        send_event(8'h61, N_BX);
        exp_ev[1] = 8'h61;
        for (int s = 0; s < N_BX; s++) tick_check(s, "R2 after drop");
        do_reset();
        check(overflow == 1'b0, "R1", "overflow cleared", W'(overflow), '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule